// File: doc/BRIEF.md
# Bicubic Resize Weight Generator

This block turns one phase weight of a 4-tap resampling filter into the four signed taps that the filter applies to source pixels at offsets -1, 0, +1 and +2. A small sharpness code picks the kernel. Code 0 gives nearest-neighbour taps and code 1 gives linear-interpolation taps. Any code of 2 or more drives a cubic convolution kernel. The kernel is evaluated in signed 16.16 fixed point at four sample distances, then rounded and saturated to 11-bit signed taps.

A requester presents the weight, the sharpness code, a downscale flag and a source-step offset, and raises `start` for one cycle while the block is idle. The block computes the kernel with a single shared registered multiplier, one tap after another. It then presents two packed coefficient words and pulses `done`. Those words feed whatever table or filter sits downstream. The phase weight is scaled so that 512 means the whole contribution comes from pixel 0 and 0 means the whole contribution comes from pixel 1.

Top module: `bcw_weight_gen`

## Requirements
- R1: A phase weight above 512 is treated as exactly 512. Weights 0..512 are used as given.
- R2: With sharpness code 0, the clamped weight is replaced by 512 when it is at least 256, and by 0 otherwise.
- R3: With codes 0 and 1, the taps at offsets -1, 0, +1, +2 are 0, w, 512-w and 0, where w is the weight after R1 and R2.
- R4: With a code c ≥ 2, the kernel parameter is a = -c·8192 in 16.16 fixed point. Let w' = 512 - w. Each tap uses the kernel value k at distance x = n·128, with n = 512+w', w', 512-w' and 1024-w' for taps 0..3. For x ≤ 65536, k = (a+2)x³ - (a+3)x² + 1. For 65536 < x ≤ 131072, k = a(x³ - 5x² + 8x - 4). Every product is the full signed product divided by 65536 with truncation toward zero.
- R5: Each cubic tap is (32768 + 512·k)/65536 with truncation toward zero, then saturated to -1024..1023.
- R6: Coefficient word 0 holds tap 0 in bits [10:0] and tap 1 in bits [21:11]. Word 1 holds tap 2 in bits [10:0] and tap 3 in bits [21:11]. All taps are two's complement, and unused bits are zero.
- R7: The 6-bit source-step offset appears unchanged in bits [27:22] of word 1. Bits [31:22] of word 0 are zero.
- R8: The downscale flag has no effect on either word.
- R9: `start` is accepted only while `busy` is low, and `busy` is high in the cycle after an accepted start. A `start` raised while busy is ignored and does not change the result of the running computation.
- R10: `done` is high for exactly one cycle per accepted start. The words change only in that cycle and hold their value until the next `done`.
- R11: After reset, `done` and `busy` are low and both words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a computation (accepted when idle) |
| weight | input | 10 | Phase weight, 512 = all pixel 0 |
| sharp | input | 6 | Sharpness code |
| downscale | input | 1 | Downscale flag (no effect on the result) |
| offset | input | 6 | Source-step offset, passed through to word 1 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle strobe, words valid |
| coef_w0 | output | 32 | Taps 0 and 1 |
| coef_w1 | output | 32 | Taps 2 and 3 and offset |

## Verification
A wrong tap index, distance or kernel branch shows up as a wrong tap field in the `done` cycle of the very computation that used it. The distances are symmetric, so a swapped index is only caught by weights other than 0, 256 and 512. For this reason the random weights cover the whole range, and sharpness codes cover the whole range as well. A sequencer that is stuck or leaks shows up as a missing or doubled `done`, a `busy` that stays low after an accepted start, or words that change outside a `done` cycle. A start that is not blocked while busy shows up as the second request's taps in the first request's result.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  localparam int DW   = 32;
  localparam int FRAC = 16;
  localparam int ONE  = 1 << FRAC;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SQ, ST_CU, ST_T1, ST_T2, ST_T3, ST_RND, ST_PACK
  } bcw_state_e;

  // signed divide by 2^FRAC with truncation toward zero
  function automatic logic signed [DW-1:0] fx_trunc(input logic signed [2*DW-1:0] p);
    logic signed [2*DW-1:0] adj;
    adj = p[2*DW-1] ? (p + ((64'sd1 <<< FRAC) - 64'sd1)) : p;
    adj = adj >>> FRAC;
    return adj[DW-1:0];
  endfunction
endpackage

// File: rtl/bcw_fmul.sv
module bcw_fmul
  import bcw_pkg::*;
(
  input  logic                 clk,
  input  logic signed [DW-1:0] op_a,
  input  logic signed [DW-1:0] op_b,
  output logic signed [DW-1:0] prod
);
  logic signed [2*DW-1:0] full;

  always_comb full = op_a * op_b;

  always_ff @(posedge clk) begin
    prod <= fx_trunc(full);
  end
endmodule

// File: rtl/bcw_round_sat.sv
module bcw_round_sat
  import bcw_pkg::*;
#(
  parameter int FULL   = 512,
  parameter int COEF_W = 11
) (
  input  logic signed [DW-1:0]     kval,
  output logic signed [COEF_W-1:0] tap
);
  localparam int FULL_LG = $clog2(FULL);
  localparam int CMAX    = (1 << (COEF_W - 1)) - 1;
  localparam int CMIN    = -(1 << (COEF_W - 1));

  logic signed [2*DW-1:0] scaled;
  logic signed [DW-1:0]   q;

  always_comb begin
    scaled = {{DW{kval[DW-1]}}, kval} <<< FULL_LG;
    scaled = scaled + (64'sd1 <<< (FRAC - 1));
    q      = fx_trunc(scaled);
    if (q > CMAX)      tap = COEF_W'(CMAX);
    else if (q < CMIN) tap = COEF_W'(CMIN);
    else               tap = q[COEF_W-1:0];
  end
endmodule

// File: rtl/bcw_pack.sv
module bcw_pack #(
  parameter int COEF_W = 11,
  parameter int OFS_W  = 6,
  parameter int WORD_W = 32
) (
  input  logic [COEF_W-1:0] t0,
  input  logic [COEF_W-1:0] t1,
  input  logic [COEF_W-1:0] t2,
  input  logic [COEF_W-1:0] t3,
  input  logic [OFS_W-1:0]  ofs,
  output logic [WORD_W-1:0] w0,
  output logic [WORD_W-1:0] w1
);
  localparam int HI_LSB  = COEF_W;
  localparam int OFS_LSB = 2 * COEF_W;

  always_comb begin
    w0 = '0;
    w1 = '0;
    w0[HI_LSB-1:0]              = t0;
    w0[OFS_LSB-1:HI_LSB]        = t1;
    w1[HI_LSB-1:0]              = t2;
    w1[OFS_LSB-1:HI_LSB]        = t3;
    w1[OFS_LSB+OFS_W-1:OFS_LSB] = ofs;
  end
endmodule

// File: rtl/bcw_weight_gen.sv
module bcw_weight_gen
  import bcw_pkg::*;
#(
  parameter int WGT_W   = 10,
  parameter int SHARP_W = 6,
  parameter int OFS_W   = 6,
  parameter int COEF_W  = 11,
  parameter int WORD_W  = 32,
  parameter int FULL    = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WGT_W-1:0]   weight,
  input  logic [SHARP_W-1:0] sharp,
  input  logic               downscale,
  input  logic [OFS_W-1:0]   offset,
  output logic               busy,
  output logic               done,
  output logic [WORD_W-1:0]  coef_w0,
  output logic [WORD_W-1:0]  coef_w1
);
  localparam int FULL_LG = $clog2(FULL);
  localparam int HALF    = FULL / 2;
  localparam int XSH     = FRAC - FULL_LG;
  localparam int A_SH    = FRAC - 3;
  localparam int NTAP    = 4;

  bcw_state_e              state;
  logic [WGT_W-1:0]        wgt_q;
  logic [OFS_W-1:0]        ofs_q;
  logic [1:0]              idx;
  logic signed [DW-1:0]    a_q, x_q, x2_q, p_q, k_q;
  logic signed [COEF_W-1:0] taps_q [NTAP];
  logic [WORD_W-1:0]       w0_q, w1_q;
  logic                    done_q;

  logic unused_dscale;
  assign unused_dscale = downscale;

  // request decode
  logic [WGT_W-1:0] wgt_cl, wgt_use;
  always_comb begin
    wgt_cl = (weight > WGT_W'(FULL)) ? WGT_W'(FULL) : weight;
    if (sharp == '0) wgt_use = (wgt_cl >= WGT_W'(HALF)) ? WGT_W'(FULL) : '0;
    else             wgt_use = wgt_cl;
  end

  // sample distance of the current tap
  logic signed [DW-1:0] wgt_s, wp_s, n_s, x_cur;
  always_comb begin
    wgt_s = $signed({{(DW-WGT_W){1'b0}}, wgt_q});
    wp_s  = FULL - wgt_s;
    case (idx)
      2'd0:    n_s = FULL + wp_s;
      2'd1:    n_s = wp_s;
      2'd2:    n_s = FULL - wp_s;
      default: n_s = 2 * FULL - wp_s;
    endcase
    x_cur = n_s <<< XSH;
  end

  // shared multiplier operand select
  logic signed [DW-1:0] mul_a, mul_b, mul_p;
  logic                 near;
  always_comb begin
    near  = (x_q <= ONE);
    mul_a = x_cur;
    mul_b = x_cur;
    case (state)
      ST_CU: begin
        mul_a = x_q;
        mul_b = mul_p;
      end
      ST_T1: begin
        if (near) begin
          mul_a = a_q + 2 * ONE;
          mul_b = mul_p;
        end else begin
          mul_a = a_q;
          mul_b = mul_p - 5 * x2_q + 8 * x_q - 4 * ONE;
        end
      end
      ST_T2: begin
        mul_a = a_q + 3 * ONE;
        mul_b = x2_q;
      end
      default: ;
    endcase
  end

  bcw_fmul u_mul (
    .clk  (clk),
    .op_a (mul_a),
    .op_b (mul_b),
    .prod (mul_p)
  );

  logic signed [COEF_W-1:0] tap_rs;
  bcw_round_sat #(.FULL(FULL), .COEF_W(COEF_W)) u_rs (
    .kval (k_q),
    .tap  (tap_rs)
  );

  logic [WORD_W-1:0] pk_w0, pk_w1;
  bcw_pack #(.COEF_W(COEF_W), .OFS_W(OFS_W), .WORD_W(WORD_W)) u_pack (
    .t0  (taps_q[0]),
    .t1  (taps_q[1]),
    .t2  (taps_q[2]),
    .t3  (taps_q[3]),
    .ofs (ofs_q),
    .w0  (pk_w0),
    .w1  (pk_w1)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      wgt_q  <= '0;
      ofs_q  <= '0;
      idx    <= '0;
      a_q    <= '0;
      x_q    <= '0;
      x2_q   <= '0;
      p_q    <= '0;
      k_q    <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < NTAP; i++) taps_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            wgt_q <= wgt_use;
            ofs_q <= offset;
            idx   <= '0;
            if (sharp < SHARP_W'(2)) begin
              taps_q[0] <= '0;
              taps_q[1] <= COEF_W'(wgt_use);
              taps_q[2] <= COEF_W'(WGT_W'(FULL) - wgt_use);
              taps_q[3] <= '0;
              state     <= ST_PACK;
            end else begin
              a_q   <= -($signed({{(DW-SHARP_W){1'b0}}, sharp}) <<< A_SH);
              state <= ST_SQ;
            end
          end
        end
        ST_SQ: begin
          x_q   <= x_cur;
          state <= ST_CU;
        end
        ST_CU: begin
          x2_q  <= mul_p;
          state <= ST_T1;
        end
        ST_T1: begin
          state <= ST_T2;
        end
        ST_T2: begin
          if (near) begin
            p_q   <= mul_p;
            state <= ST_T3;
          end else begin
            k_q   <= mul_p;
            state <= ST_RND;
          end
        end
        ST_T3: begin
          k_q   <= p_q - mul_p + ONE;
          state <= ST_RND;
        end
        ST_RND: begin
          taps_q[idx] <= tap_rs;
          idx         <= idx + 2'd1;
          state       <= (idx == 2'd3) ? ST_PACK : ST_SQ;
        end
        ST_PACK: begin
          w0_q   <= pk_w0;
          w1_q   <= pk_w1;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = done_q;
  assign coef_w0 = w0_q;
  assign coef_w1 = w1_q;
endmodule

// File: rtl/bcw_weight_gen_chk.sv
module bcw_weight_gen_chk #(
  parameter int WGT_W   = 10,
  parameter int SHARP_W = 6,
  parameter int OFS_W   = 6,
  parameter int COEF_W  = 11,
  parameter int WORD_W  = 32,
  parameter int FULL    = 512
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [WGT_W-1:0]   weight,
  input logic [SHARP_W-1:0] sharp,
  input logic               downscale,
  input logic [OFS_W-1:0]   offset,
  input logic               busy,
  input logic               done,
  input logic [WORD_W-1:0]  coef_w0,
  input logic [WORD_W-1:0]  coef_w1
);
  localparam int OFS_LSB = 2 * COEF_W;

  logic [SHARP_W-1:0] code_l;
  logic [OFS_W-1:0]   ofs_l;
  logic unused_chk;
  assign unused_chk = ^{weight, downscale};

  always_ff @(posedge clk) begin
    if (rst) begin
      code_l <= '0;
      ofs_l  <= '0;
    end else if (start && !busy) begin
      code_l <= sharp;
      ofs_l  <= offset;
    end
  end

  int t0, t1, t2, t3;
  always_comb begin
    t0 = int'($signed(coef_w0[COEF_W-1:0]));
    t1 = int'($signed(coef_w0[2*COEF_W-1:COEF_W]));
    t2 = int'($signed(coef_w1[COEF_W-1:0]));
    t3 = int'($signed(coef_w1[2*COEF_W-1:COEF_W]));
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(coef_w0) && $stable(coef_w1))); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    done |-> (coef_w1[OFS_LSB +: OFS_W] == ofs_l)); // R7
  AST_LINEAR_TAPS: assert property (@(posedge clk) disable iff (rst)
    (done && code_l < SHARP_W'(2)) |-> (t0 == 0 && t3 == 0 && t1 + t2 == FULL)); // R3
  AST_NEAREST_SNAP: assert property (@(posedge clk) disable iff (rst)
    (done && code_l == '0) |-> (t1 == 0 || t1 == FULL)); // R2
endmodule

bind bcw_weight_gen bcw_weight_gen_chk #(
  .WGT_W(WGT_W), .SHARP_W(SHARP_W), .OFS_W(OFS_W),
  .COEF_W(COEF_W), .WORD_W(WORD_W), .FULL(FULL)
) u_chk (.*);

// File: tb/bcw_weight_gen_bench.sv
`timescale 1ns/1ps
module bcw_weight_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [9:0]  weight = '0;
  logic [5:0]  sharp = '0;
  logic        downscale = 1'b0;
  logic [5:0]  offset = '0;
  logic        busy, done;
  logic [31:0] coef_w0, coef_w1;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bcw_weight_gen u_bcw_weight_gen (
    .clk(clk), .rst(rst), .start(start), .weight(weight), .sharp(sharp),
    .downscale(downscale), .offset(offset), .busy(busy), .done(done),
    .coef_w0(coef_w0), .coef_w1(coef_w1)
  );

  // ---------------- reference model from the requirements
  function automatic longint fm(longint a, longint b);
    return (a * b) / 65536;
  endfunction

  function automatic longint kern(longint a, longint x);
    longint x2, x3;
    x2 = fm(x, x);
    x3 = fm(x, x2);
    if (x <= 65536)       return fm(a + 131072, x3) - fm(a + 196608, x2) + 65536;
    else if (x <= 131072) return fm(a, x3 - 5 * x2 + 8 * x - 262144);
    else                  return 0;
  endfunction

  function automatic longint model_tap(int w_in, int code, int i);
    longint w, wp, n, k, t;
    w = (w_in > 512) ? 512 : w_in;                       // R1
    if (code == 0) w = (w >= 256) ? 512 : 0;             // R2
    if (code < 2) begin                                   // R3
      case (i)
        1: return w;
        2: return 512 - w;
        default: return 0;
      endcase
    end
    wp = 512 - w;                                         // R4
    case (i)
      0: n = 512 + wp;
      1: n = wp;
      2: n = 512 - wp;
      default: n = 1024 - wp;
    endcase
    k = kern(-longint'(code) * 8192, n * 128);
    t = (32768 + 512 * k) / 65536;                        // R5
    if (t > 1023)  t = 1023;
    if (t < -1024) t = -1024;
    return t;
  endfunction

  function automatic logic [31:0] mkword(longint lo, longint hi, int ofs);
    logic [31:0] r;
    r = '0;
    r[10:0]  = 11'(lo);                                   // R6
    r[21:11] = 11'(hi);
    r[27:22] = 6'(ofs);                                   // R7
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request; returns captured words
  task automatic run(input int w, input int code, input bit ds, input int ofs,
                     output logic [31:0] r0, output logic [31:0] r1, output bit got);
    @(negedge clk);
    weight = 10'(w); sharp = 6'(code); downscale = ds; offset = 6'(ofs); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9 busy after start", 32'(busy), 32'd1);
    got = 1'b0;
    for (int c = 0; c < 200 && !got; c++) begin
      if (done === 1'b1) got = 1'b1;
      else @(negedge clk);
    end
    r0 = coef_w0; r1 = coef_w1;
    check(got, "R10 done seen", 32'(got), 32'd1);
    @(negedge clk);
    check(done === 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    check(coef_w0 === r0 && coef_w1 === r1, "R10 words hold", coef_w0, r0);
  endtask

  task automatic run_check(input int w, input int code, input bit ds, input int ofs, input string req);
    logic [31:0] r0, r1, e0, e1;
    bit got;
    e0 = mkword(model_tap(w, code, 0), model_tap(w, code, 1), 0);
    e1 = mkword(model_tap(w, code, 2), model_tap(w, code, 3), ofs);
    run(w, code, ds, ofs, r0, r1, got);
    check(r0 === e0, {req, " word0"}, r0, e0);
    check(r1 === e1, {req, " word1"}, r1, e1);
  endtask

  initial begin : watchdog
    #1_500_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] a0, a1, b0, b1;
    bit g;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(done === 1'b0 && busy === 1'b0, "R11 flags after reset", {30'd0, busy, done}, 32'd0);
    check(coef_w0 === 32'd0 && coef_w1 === 32'd0, "R11 words after reset", coef_w0 | coef_w1, 32'd0);

    // directed corners
    run_check(300, 0, 0, 5,  "R2 snap high");
    run_check(255, 0, 0, 1,  "R2 snap low");
    run_check(256, 0, 0, 0,  "R2 snap boundary");
    run_check(300, 1, 0, 63, "R3 linear");
    run_check(0,   1, 0, 2,  "R3 linear zero weight");
    run_check(700, 1, 0, 3,  "R1 clamp linear");
    run_check(1023, 8, 0, 7, "R1 clamp cubic");
    run_check(512, 8, 0, 0,  "R4 cubic full weight");
    run_check(256, 8, 0, 9,  "R4 cubic half");
    run_check(0,   2, 0, 1,  "R4 cubic code2 zero weight");
    run_check(100, 32, 0, 4, "R5 cubic code32");
    run_check(411, 63, 0, 33, "R5 cubic top code");
    run_check(77, 17, 0, 42, "R6 field layout");

    // R8 downscale has no effect
    run(333, 12, 1'b0, 11, a0, a1, g);
    run(333, 12, 1'b1, 11, b0, b1, g);
    check(a0 === b0 && a1 === b1, "R8 downscale ignored", b0 ^ b1, a0 ^ a1);

    // R9 start while busy ignored
    begin
      logic [31:0] e0, e1;
      bit got;
      e0 = mkword(model_tap(190, 9, 0), model_tap(190, 9, 1), 0);
      e1 = mkword(model_tap(190, 9, 2), model_tap(190, 9, 3), 21);
      @(negedge clk);
      weight = 10'd190; sharp = 6'd9; offset = 6'd21; start = 1'b1;
      @(negedge clk);
      weight = 10'd20; sharp = 6'd1; offset = 6'd50;
      check(busy === 1'b1, "R9 busy", 32'(busy), 32'd1);
      repeat (3) @(negedge clk);
      start = 1'b0;
      got = 1'b0;
      for (int c = 0; c < 200 && !got; c++) begin
        if (done === 1'b1) got = 1'b1;
        else @(negedge clk);
      end
      check(coef_w0 === e0 && coef_w1 === e1, "R9 second start ignored", coef_w1, e1);
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R9 no second result", {30'd0, busy, done}, 32'd0);
    end

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int w, code, ofs;
      w    = int'($urandom_range(0, 600));
      code = int'($urandom_range(0, 32));
      if ($urandom_range(0, 9) == 0) code = int'($urandom_range(33, 63));
      ofs  = int'($urandom_range(0, 63));
      run_check(w, code, 1'($urandom_range(0, 1)), ofs, "R4 R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule